// File: doc/BRIEF.md
# Slot Reset and Clock-Enable Sequencer

This block drives the active-low reset to a removable card slot, along with the pull-down for a shared open-drain pin. That pin tells the host that slot power is good, and the host can also hold it low to keep the card in reset. The block takes three power-good flags, one for each switched output rail. It also takes a mode code from the slot power controller, an active-low system reset, and the sampled level of the shared pin.

Reset to the card is asserted at once when any rail fails, when the slot leaves its powered mode, or when system reset is driven low. After an assertion, reset stays low for a minimum pulse width. Reset is released only when all of the following hold: the rails have been good without a break for a long settling window, system reset is high, and the shared pin reads high. The pin pull-down carries no delay. It lets go as soon as the slot is powered, all rails are good and system reset is high. All timing is counted in clock cycles, and each count is a parameter.

Top module: `slot_perst_seq`

## Requirements
- R1: After the synchronous reset, `perst_n` is 0 and `clken_pull_dn` is 1.
- R2: If any `pg_ok` bit is 0 at a clock edge while the mode is powered, `perst_n` is 0 after that same edge.
- R3: `perst_n` rises only at the (RELEASE_CYC+1)-th edge of an unbroken run of edges at which the mode is powered and `pg_ok` is 3'b111. If system reset, the pin and the pulse timer already allow release, it rises at exactly that edge.
- R4: A break of even one cycle in the power-good run restarts the settling window, and the count starts again from the edge at which the condition returns.
- R5: `sys_rst_n` passes through a two-flop synchronizer. A low level asserts `perst_n` low by the third edge after it is applied. After release, with power settled and the pulse timer done, `perst_n` returns high within 8 cycles.
- R6: Each low period of `perst_n` lasts at least MIN_PULSE_CYC cycles, whether a rail drop or system reset caused it.
- R7: `clken_pull_dn` is 0 only when the mode is powered, all three `pg_ok` bits are 1 and the synchronized system reset is high. It goes to 1 at the first edge after any of these conditions fails.
- R8: While the sampled `clken_pin_in` is low (host hold-off), `perst_n` is held at 0 even when every other release condition is met. It rises within 5 cycles after the pin returns high.
- R9: Mode codes are OFF=0, SHUTDOWN=1, NO_CARD=2, STANDBY=3 and POWERED=4, and codes 5 to 7 count as unpowered. In every code except POWERED, `perst_n` is 0 and `clken_pull_dn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_ok | input | 3 | Power-good flags of the three switched outputs |
| slot_mode | input | 3 | Mode code from the slot power controller |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous to clk |
| clken_pin_in | input | 1 | Sampled level of the shared open-drain pin |
| clken_pull_dn | output | 1 | 1 enables the pull-down on the shared pin |
| perst_n | output | 1 | Active-low reset to the card |

## Verification
A settling counter that fails to restart would let `perst_n` rise too early after a short rail glitch. The port checks catch this as a rise fewer than RELEASE_CYC+1 edges after the condition returned. A pulse timer that is loaded late or never loaded shows up as a low pulse shorter than MIN_PULSE_CYC after a one-cycle system-reset dip. A bad synchronizer depth or a broken hold-off path changes the edge at which `perst_n` falls or rises. The bench sees this within a few cycles, because it compares against histories of `sys_rst_n` and the pin hold that it keeps itself.

// File: rtl/slot_perst_pkg.sv
package slot_perst_pkg;

    typedef enum logic [2:0] {
        SLOT_OFF      = 3'd0,
        SLOT_SHUTDOWN = 3'd1,
        SLOT_NO_CARD  = 3'd2,
        SLOT_STANDBY  = 3'd3,
        SLOT_POWERED  = 3'd4
    } slot_mode_e;

    localparam int RAIL_COUNT = 3;

    // Synchronized host-side view
    typedef struct packed {
        logic host_run;   // system reset released
        logic pin_high;   // shared pin reads high
    } host_view_t;

    // Conditions that feed the reset decision
    typedef struct packed {
        logic pwr_good;   // powered mode with every rail good
        logic settled;    // pwr_good held for the whole window
        logic pulse_busy; // minimum pulse still running
    } rel_cond_t;

    function automatic logic mode_is_powered(input logic [2:0] code);
        return code == SLOT_POWERED;
    endfunction

    function automatic logic rails_all_good(input logic [RAIL_COUNT-1:0] flags);
        return &flags;
    endfunction

endpackage

// File: rtl/slot_bit_sync.sv
module slot_bit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/slot_settle_timer.sv
module slot_settle_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == LIMIT_V);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (!done)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/slot_pulse_stretch.sv
module slot_pulse_stretch #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    logic [CW-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || trig) cnt_q <= LEN_V;
        else if (busy)   cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/slot_perst_seq.sv
module slot_perst_seq
    import slot_perst_pkg::*;
#(
    parameter int RELEASE_CYC   = 1_000_000,
    parameter int MIN_PULSE_CYC = 10_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RAIL_COUNT-1:0] pg_ok,
    input  logic [2:0]            slot_mode,
    input  logic                  sys_rst_n,
    input  logic                  clken_pin_in,
    output logic                  clken_pull_dn,
    output logic                  perst_n
);
    logic [1:0] sync_q;
    host_view_t host;
    rel_cond_t  cond;
    logic       force_low;
    logic       perst_q;
    logic       pull_q;

    slot_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sys_rst_n, clken_pin_in}),
        .q   (sync_q)
    );

    assign host.host_run = sync_q[1];
    assign host.pin_high = sync_q[0];

    assign cond.pwr_good = mode_is_powered(slot_mode) && rails_all_good(pg_ok);

    slot_settle_timer #(.LIMIT(RELEASE_CYC)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .run  (cond.pwr_good),
        .done (cond.settled)
    );

    assign force_low = !(cond.pwr_good && host.host_run);

    slot_pulse_stretch #(.LEN(MIN_PULSE_CYC)) u_stretch (
        .clk  (clk),
        .rst  (rst),
        .trig (perst_q && force_low),
        .busy (cond.pulse_busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            perst_q <= 1'b0;
        else if (force_low)
            perst_q <= 1'b0;
        else if (cond.settled && host.pin_high && !cond.pulse_busy)
            perst_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pull_q <= 1'b1;
        else     pull_q <= force_low;
    end

    assign perst_n       = perst_q;
    assign clken_pull_dn = pull_q;
endmodule

// File: rtl/slot_perst_chk.sv
module slot_perst_chk
    import slot_perst_pkg::*;
#(
    parameter int RELEASE_CYC   = 1_000_000,
    parameter int MIN_PULSE_CYC = 10_000
) (
    input logic                  clk,
    input logic                  rst,
    input logic [RAIL_COUNT-1:0] pg_ok,
    input logic [2:0]            slot_mode,
    input logic                  clken_pin_in,
    input logic                  clken_pull_dn,
    input logic                  perst_n
);
    localparam int RW = $clog2(RELEASE_CYC + 2);
    localparam int LW = $clog2(MIN_PULSE_CYC + 1);

    logic          pg_all;
    logic [RW-1:0] pg_run_q;
    logic [LW-1:0] low_run_q;

    assign pg_all = mode_is_powered(slot_mode) && rails_all_good(pg_ok);

    always_ff @(posedge clk) begin
        if (rst || !pg_all)                   pg_run_q <= '0;
        else if (pg_run_q != RW'(RELEASE_CYC + 1)) pg_run_q <= pg_run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || perst_n)                     low_run_q <= '0;
        else if (low_run_q != LW'(MIN_PULSE_CYC)) low_run_q <= low_run_q + 1'b1;
    end

    // R2
    pg_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pg_all |=> !perst_n);

    // R3
    release_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_n) |-> (pg_run_q >= RW'(RELEASE_CYC)));

    // R6
    min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_n) |-> (low_run_q >= LW'(MIN_PULSE_CYC)));

    // R7
    pull_dn_chk: assert property (@(posedge clk) disable iff (rst)
        !pg_all |=> clken_pull_dn);

    // R8
    holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_n) |-> $past(clken_pin_in, 3));

    // R9
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_mode != SLOT_POWERED) |=> (!perst_n && clken_pull_dn));
endmodule

bind slot_perst_seq slot_perst_chk #(
    .RELEASE_CYC   (RELEASE_CYC),
    .MIN_PULSE_CYC (MIN_PULSE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pg_ok         (pg_ok),
    .slot_mode     (slot_mode),
    .clken_pin_in  (clken_pin_in),
    .clken_pull_dn (clken_pull_dn),
    .perst_n       (perst_n)
);

// File: tb/sim_slot_perst_seq.sv
`timescale 1ns/1ps
module sim_slot_perst_seq;
    localparam int DLY = 200;
    localparam int MINP = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pg = 3'b000;
    logic [2:0] mode = 3'd0;
    logic       sys_n = 1'b0;
    logic       hold = 1'b0;
    logic       pin;
    logic       pull_dn;
    logic       perst_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pin = !pull_dn && !hold;

    slot_perst_seq #(.RELEASE_CYC(DLY), .MIN_PULSE_CYC(MINP)) u0 (
        .clk (clk), .rst (rst), .pg_ok (pg), .slot_mode (mode),
        .sys_rst_n (sys_n), .clken_pin_in (pin),
        .clken_pull_dn (pull_dn), .perst_n (perst_n)
    );

    function automatic bit pg_all_f(input logic [2:0] m, input logic [2:0] p);
        return (m == 3'd4) && (p == 3'b111);
    endfunction

    // bench-side histories, sampled at posedge from bench-driven inputs
    int       pg_run = 0;
    logic [2:0] sys_hist = 3'b000;
    logic [2:0] hold_hist = 3'b000;
    always @(posedge clk) begin
        if (rst) pg_run <= 0;
        else     pg_run <= pg_all_f(mode, pg) ? pg_run + 1 : 0;
        sys_hist  <= {sys_hist[1:0], sys_n};
        hold_hist <= {hold_hist[1:0], hold};
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_to_high(output int n);
        n = 0;
        while (!perst_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(150_000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int lowc;
        int prev_low;
        logic prev_p;
        logic [2:0] modes [7];
        modes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7};

        wait_n(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(perst_n == 1'b0, "R1 perst_n", perst_n, 0);
        chk(pull_dn == 1'b1, "R1 pull_dn", pull_dn, 1);

        // R3 exact release edge
        sys_n = 1'b1; mode = 3'd4; pg = 3'b111;
        wait_n(DLY);
        chk(perst_n == 1'b0, "R3 still low at window end", perst_n, 0);
        chk(pull_dn == 1'b0, "R7 pull released", pull_dn, 0);
        @(negedge clk);
        chk(perst_n == 1'b1, "R3 release edge", perst_n, 1);

        // R2 / R4 glitch restarts window
        wait_n(20);
        pg = 3'b101;
        @(negedge clk);
        chk(perst_n == 1'b0, "R2 rail drop", perst_n, 0);
        chk(pull_dn == 1'b1, "R7 pull on drop", pull_dn, 1);
        pg = 3'b111;
        wait_n(80);
        pg = 3'b011;
        @(negedge clk);
        pg = 3'b111;
        wait_n(DLY);
        chk(perst_n == 1'b0, "R4 restart low", perst_n, 0);
        @(negedge clk);
        chk(perst_n == 1'b1, "R4 restart release", perst_n, 1);

        // R5 system reset
        sys_n = 1'b0;
        wait_n(3);
        chk(perst_n == 1'b0, "R5 sysrst assert", perst_n, 0);
        chk(pull_dn == 1'b1, "R7 pull on sysrst", pull_dn, 1);
        wait_n(MINP + 50);
        sys_n = 1'b1;
        count_to_high(n);
        chk(n >= 1 && n <= 8, "R5 sysrst release latency", n, 6);

        // R6 one-cycle sysrst dip
        wait_n(10);
        sys_n = 1'b0;
        @(negedge clk);
        sys_n = 1'b1;
        wait_n(3);
        chk(perst_n == 1'b0, "R5 short dip asserts", perst_n, 0);
        count_to_high(lowc);
        lowc += 1;
        chk(lowc >= MINP && lowc <= MINP + 10, "R6 min pulse", lowc, MINP + 1);

        // R8 host hold-off
        wait_n(10);
        hold = 1'b1; sys_n = 1'b0;
        @(negedge clk);
        sys_n = 1'b1;
        wait_n(MINP + 100);
        chk(perst_n == 1'b0, "R8 held by pin", perst_n, 0);
        chk(pull_dn == 1'b0, "R7 pull off under hold", pull_dn, 0);
        hold = 1'b0;
        count_to_high(n);
        chk(n >= 1 && n <= 5, "R8 release after pin", n, 3);

        // R9 every unpowered mode code
        foreach (modes[k]) begin
            mode = modes[k];
            wait_n(2);
            chk(perst_n == 1'b0, "R9 perst in mode", perst_n, 0);
            chk(pull_dn == 1'b1, "R9 pull in mode", pull_dn, 1);
            mode = 3'd4;
            wait_n(DLY + 5);
            chk(perst_n == 1'b1, "R9 back to powered", perst_n, 1);
        end

        // random phase
        void'($urandom(32'd20240611));
        prev_low = 0;
        prev_p = perst_n;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if (perst_n) begin
                chk(pg_run >= DLY + 1, "R3 random settle", pg_run, DLY + 1);
                chk(sys_hist[2] == 1'b1, "R5 random sysrst", sys_hist[2], 1);
                if (!prev_p) begin
                    chk(prev_low >= MINP, "R6 random pulse", prev_low, MINP);
                    chk(hold_hist[2] == 1'b0, "R8 random hold", hold_hist[2], 0);
                end
            end
            if (pg_run == 0) begin
                chk(!perst_n && pull_dn, "R2 random drop", {perst_n, pull_dn}, 1);
            end
            if (sys_hist[2] == 1'b0) begin
                chk(!perst_n && pull_dn, "R5 random sysrst low", {perst_n, pull_dn}, 1);
            end
            prev_low = perst_n ? 0 : prev_low + 1;
            prev_p = perst_n;
            if ($urandom_range(0, 499) == 0) pg = 3'($urandom_range(0, 6));
            else if ($urandom_range(0, 19) == 0) pg = 3'b111;
            if ($urandom_range(0, 999) == 0) mode = 3'($urandom_range(0, 7));
            else if ($urandom_range(0, 29) == 0) mode = 3'd4;
            sys_n = ($urandom_range(0, 699) == 0) ? 1'b0 : 1'b1;
            if ($urandom_range(0, 799) == 0) hold = 1'b1;
            else if ($urandom_range(0, 39) == 0) hold = 1'b0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule